// File: doc/BRIEF.md
# External Memory Access Timing Sequencer

The sequencer runs one access at a time to an external parallel device: an SRAM-like part, a NOR-flash-like part or a pseudo-SRAM. A request carries an address, write data, byte enables, a direction and a chip-select index. When the request is accepted, the block latches the timing profile of that chip select. It then steps a cycle counter through the access. The counter value decides the chip select, address-valid strobe, output enable, write enable, byte-lane enables and the shared data bus. All timing is counted in functional-clock cycles.

Each chip-select profile sets several things: the edges of every control strobe, the cycle on which read data is captured, and the last cycle of the access. It also sets the number of idle turnaround cycles that follow the access, the bus width (8 or 16 bits), the address multiplexing mode and whether the external wait input is honoured. A one-cycle done pulse closes each access. The pulse comes with the captured read data. The request port then accepts again once the turnaround cycles have passed.

Top module: `ext_mem_seq`

## Requirements
- R1: While rst_ni is low and directly after reset, req_ready_o is 1, every cs_n_o bit, adv_n_o, oe_n_o and we_n_o are 1, done_o and dq_oe_o are 0.
- R2: With t the access counter (0 on the first cycle after acceptance), the selected chip select is low for cs_on <= t < cyc. Every other chip select stays high, and no chip select is low outside an access or during turnaround.
- R3: On a read, oe_n_o is low for oe_on <= t < oe_off and we_n_o stays high. On a write, we_n_o is low for we_on <= t < we_off and oe_n_o stays high.
- R4: adv_n_o is low for t < adv_len in modes 0 and 1, and for t < 2*adv_len in mode 2.
- R5: The mux field picks the address mode: 0 separate address, 1 address on data bus, 2 two address phases. In mode 1 the data bus drives addr[15:0] for t < adv_len. In mode 2 it drives addr >> 16 for t < adv_len, then addr[15:0] for adv_len <= t < 2*adv_len.
- R6: On a write, dq_oe_o is 1 and dq_o carries the write data from the data-start cycle (0, adv_len or 2*adv_len by mode) until t = cyc. In 8-bit mode the upper byte is driven as zero. On a read the bus is not driven after the address phases.
- R7: done_o pulses for exactly the cycle t = cyc. req_ready_o is 0 from acceptance until turn cycles after that pulse, then returns to 1.
- R8: Read data is sampled from dq_i on the t = acc cycle. Byte lane 0 is dq[7:0] (little-endian). In 8-bit mode the upper byte of the result is zero. The data stays on rdata_o through done_o and afterwards.
- R9: If wait_en is set, wait_i high while oe_n_o or we_n_o is low freezes the counter, so every output holds and the access grows by one cycle. If wait_en is clear, wait_i has no effect.
- R10: While dq_oe_o is 0, dq_o keeps the last value it drove.
- R11: While the chip select is low, be_n_o is the inverse of the byte enables, with lane 1 forced high in 8-bit mode. Otherwise be_n_o is all ones.
- R12: cfg_i holds one 49-bit profile per chip select, CS0 at the low end. Fields run from MSB: cs_on, adv_len, oe_on, oe_off, we_on, we_off, acc, cyc, turn (5 bits each), mux (2), wide (1, 1 = 16-bit), wait_en (1). The profile is latched at acceptance, so cfg_i changes during an access have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | functional clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cfg_i | input | NUM_CS*49 | per-chip-select timing profiles |
| req_valid_i | input | 1 | request valid |
| req_ready_o | output | 1 | request accepted when high with valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_cs_i | input | CS_W | chip-select index |
| req_addr_i | input | ADDR_W | device address |
| req_wdata_i | input | DQ_W | write data |
| req_be_i | input | BE_W | byte enables, bit 0 = lane 0 |
| done_o | output | 1 | access complete pulse |
| rdata_o | output | DQ_W | captured read data |
| cs_n_o | output | NUM_CS | chip selects, active low |
| adv_n_o | output | 1 | address valid, active low |
| oe_n_o | output | 1 | output enable, active low |
| we_n_o | output | 1 | write enable, active low |
| be_n_o | output | BE_W | byte-lane enables, active low |
| addr_o | output | ADDR_W | address lines |
| dq_o | output | DQ_W | data bus out value |
| dq_oe_o | output | 1 | data bus drive enable |
| dq_i | input | DQ_W | data bus in value |
| wait_i | input | 1 | external wait, active high |

## Verification
The sweep covers all four chip-select profiles. Each profile gives a different mode, width, wait policy and turnaround, so a wrong profile select or a wrong mode decode shows up as misplaced edges. Each profile runs reads and writes, with and without a two-cycle wait burst inside the strobe. The wait runs separate a frozen counter from one that ignores the pin, and a capture on the programmed cycle from one taken during the freeze. On alternate runs cfg_i is inverted mid-access. This shows whether the latched profile or the live input drives the pins.

// File: rtl/emseq_pkg.sv
package emseq_pkg;
  localparam int CNT_W = 5;

  typedef enum logic [1:0] {
    MUX_NONE = 2'd0,
    MUX_AD   = 2'd1,
    MUX_AAD  = 2'd2
  } mux_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_TURN = 2'd2
  } st_e;

  typedef struct packed {
    logic [CNT_W-1:0] cs_on;
    logic [CNT_W-1:0] adv_len;
    logic [CNT_W-1:0] oe_on;
    logic [CNT_W-1:0] oe_off;
    logic [CNT_W-1:0] we_on;
    logic [CNT_W-1:0] we_off;
    logic [CNT_W-1:0] acc;
    logic [CNT_W-1:0] cyc;
    logic [CNT_W-1:0] turn;
    mux_e             mux;
    logic             wide;
    logic             wait_en;
  } cs_cfg_t;

  localparam int CFG_W = $bits(cs_cfg_t);
endpackage

// File: rtl/emseq_cfg_sel.sv
module emseq_cfg_sel
  import emseq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2
) (
  input  logic [NUM_CS*CFG_W-1:0] cfg_i,
  input  logic [CS_W-1:0]         sel_i,
  output cs_cfg_t                 cfg_o
);
  cs_cfg_t prof [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
    assign prof[g] = cs_cfg_t'(cfg_i[g*CFG_W +: CFG_W]);
  end

  always_comb begin
    cfg_o = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (sel_i == CS_W'(i)) cfg_o = prof[i];
    end
  end
endmodule

// File: rtl/emseq_timer.sv
module emseq_timer
  import emseq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             frozen_i,
  input  logic [CNT_W-1:0] cyc_i,
  input  logic [CNT_W-1:0] turn_i,
  output st_e              st_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o,
  output logic             ready_o
);
  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_ACC;
          cnt_q <= '0;
        end
        ST_ACC: begin
          if (cnt_q == cyc_i) begin
            cnt_q <= '0;
            st_q  <= (turn_i == '0) ? ST_IDLE : ST_TURN;
          end else if (!frozen_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_TURN: begin
          if (cnt_q == turn_i - CNT_W'(1)) begin
            cnt_q <= '0;
            st_q  <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign st_o    = st_q;
  assign cnt_o   = cnt_q;
  assign done_o  = (st_q == ST_ACC) && (cnt_q == cyc_i);
  assign ready_o = (st_q == ST_IDLE);
endmodule

// File: rtl/emseq_pins.sv
module emseq_pins
  import emseq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int CS_W   = 2,
  parameter int ADDR_W = 24,
  parameter int DQ_W   = 16,
  parameter int BE_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  st_e               st_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  cs_cfg_t           cfg_i,
  input  logic [CS_W-1:0]   cs_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   wdata_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DQ_W-1:0]   dq_i,
  input  logic              wait_i,
  output logic [NUM_CS-1:0] cs_n_o,
  output logic              adv_n_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic [BE_W-1:0]   be_n_o,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  output logic [DQ_W-1:0]   rdata_o,
  output logic              frozen_o
);
  localparam int NARROW_W = 8;
  localparam logic [DQ_W-1:0] NARROW_MASK = DQ_W'({NARROW_W{1'b1}});

  logic             in_acc, cs_act, oe_act, we_act, ph1, ph2, data_ph;
  logic [CNT_W:0]   c_ext, adv1, adv2, dstart, adv_end;
  logic [DQ_W-1:0]  addr_hi, addr_lo, wd, drv, keep_q, rdata_q;

  assign in_acc = (st_i == ST_ACC);
  assign c_ext  = {1'b0, cnt_i};
  assign adv1   = {1'b0, cfg_i.adv_len};
  assign adv2   = {cfg_i.adv_len, 1'b0};

  always_comb begin
    unique case (cfg_i.mux)
      MUX_AD:  dstart = adv1;
      MUX_AAD: dstart = adv2;
      default: dstart = '0;
    endcase
  end
  assign adv_end = (cfg_i.mux == MUX_AAD) ? adv2 : adv1;

  assign cs_act  = in_acc && (cnt_i >= cfg_i.cs_on) && (cnt_i < cfg_i.cyc);
  assign oe_act  = in_acc && !write_i && (cnt_i >= cfg_i.oe_on) && (cnt_i < cfg_i.oe_off);
  assign we_act  = in_acc && write_i && (cnt_i >= cfg_i.we_on) && (cnt_i < cfg_i.we_off);
  assign ph1     = in_acc && (cfg_i.mux != MUX_NONE) && (c_ext < adv1);
  assign ph2     = in_acc && (cfg_i.mux == MUX_AAD) && (c_ext >= adv1) && (c_ext < adv2);
  assign data_ph = in_acc && write_i && (c_ext >= dstart) && (cnt_i < cfg_i.cyc);

  // strobe phase stalls while the device holds wait
  assign frozen_o = cfg_i.wait_en && wait_i && (oe_act || we_act);

  assign addr_hi = DQ_W'(addr_i >> DQ_W);
  assign addr_lo = addr_i[DQ_W-1:0];
  assign wd      = cfg_i.wide ? wdata_i : (wdata_i & NARROW_MASK);

  always_comb begin
    if (ph1)      drv = (cfg_i.mux == MUX_AAD) ? addr_hi : addr_lo;
    else if (ph2) drv = addr_lo;
    else          drv = wd;
  end

  assign dq_oe_o = ph1 || ph2 || data_ph;
  assign dq_o    = dq_oe_o ? drv : keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep_q  <= '0;
      rdata_q <= '0;
    end else begin
      keep_q <= dq_o;
      if (in_acc && !write_i && (cnt_i == cfg_i.acc) && !frozen_o)
        rdata_q <= cfg_i.wide ? dq_i : (dq_i & NARROW_MASK);
    end
  end
  assign rdata_o = rdata_q;

  always_comb begin
    for (int i = 0; i < NUM_CS; i++) cs_n_o[i] = !(cs_act && (cs_i == CS_W'(i)));
  end

  assign adv_n_o = !(in_acc && (c_ext < adv_end));
  assign oe_n_o  = !oe_act;
  assign we_n_o  = !we_act;
  assign be_n_o  = cs_act ? ~(cfg_i.wide ? be_i : (be_i & BE_W'(1))) : '1;
endmodule

// File: rtl/ext_mem_seq.sv
module ext_mem_seq
  import emseq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int ADDR_W = 24,
  parameter int DQ_W   = 16,
  localparam int CS_W  = $clog2(NUM_CS),
  localparam int BE_W  = DQ_W / 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CS*CFG_W-1:0] cfg_i,
  input  logic                    req_valid_i,
  output logic                    req_ready_o,
  input  logic                    req_write_i,
  input  logic [CS_W-1:0]         req_cs_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic [DQ_W-1:0]         req_wdata_i,
  input  logic [BE_W-1:0]         req_be_i,
  output logic                    done_o,
  output logic [DQ_W-1:0]         rdata_o,
  output logic [NUM_CS-1:0]       cs_n_o,
  output logic                    adv_n_o,
  output logic                    oe_n_o,
  output logic                    we_n_o,
  output logic [BE_W-1:0]         be_n_o,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [DQ_W-1:0]         dq_o,
  output logic                    dq_oe_o,
  input  logic [DQ_W-1:0]         dq_i,
  input  logic                    wait_i
);
  cs_cfg_t           sel_cfg, cur_cfg;
  logic [CS_W-1:0]   cs_q;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   wdata_q;
  logic [BE_W-1:0]   be_q;
  logic              start, frozen;
  st_e               st;
  logic [CNT_W-1:0]  cnt;

  assign start = req_valid_i && req_ready_o;

  emseq_cfg_sel #(.NUM_CS(NUM_CS), .CS_W(CS_W)) u_sel (
    .cfg_i (cfg_i),
    .sel_i (req_cs_i),
    .cfg_o (sel_cfg)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_cfg <= '0;
      cs_q    <= '0;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (start) begin
      cur_cfg <= sel_cfg;
      cs_q    <= req_cs_i;
      write_q <= req_write_i;
      addr_q  <= req_addr_i;
      wdata_q <= req_wdata_i;
      be_q    <= req_be_i;
    end
  end

  emseq_timer u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .frozen_i (frozen),
    .cyc_i    (cur_cfg.cyc),
    .turn_i   (cur_cfg.turn),
    .st_o     (st),
    .cnt_o    (cnt),
    .done_o   (done_o),
    .ready_o  (req_ready_o)
  );

  emseq_pins #(
    .NUM_CS(NUM_CS), .CS_W(CS_W), .ADDR_W(ADDR_W), .DQ_W(DQ_W), .BE_W(BE_W)
  ) u_pins (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .st_i     (st),
    .cnt_i    (cnt),
    .cfg_i    (cur_cfg),
    .cs_i     (cs_q),
    .write_i  (write_q),
    .addr_i   (addr_q),
    .wdata_i  (wdata_q),
    .be_i     (be_q),
    .dq_i     (dq_i),
    .wait_i   (wait_i),
    .cs_n_o   (cs_n_o),
    .adv_n_o  (adv_n_o),
    .oe_n_o   (oe_n_o),
    .we_n_o   (we_n_o),
    .be_n_o   (be_n_o),
    .dq_o     (dq_o),
    .dq_oe_o  (dq_oe_o),
    .rdata_o  (rdata_o),
    .frozen_o (frozen)
  );

  assign addr_o = addr_q;
endmodule

// File: rtl/emseq_chk.sv
module emseq_chk
  import emseq_pkg::*;
#(
  parameter int NUM_CS = 4,
  parameter int DQ_W   = 16,
  parameter int BE_W   = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CS-1:0] cs_n_o,
  input logic              oe_n_o,
  input logic              we_n_o,
  input logic              done_o,
  input logic              req_ready_o,
  input logic [DQ_W-1:0]   dq_o,
  input logic              dq_oe_o,
  input logic [BE_W-1:0]   be_n_o,
  input logic              frozen,
  input logic [CNT_W-1:0]  cnt
);
  // R2
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));

  // R3
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!oe_n_o && !we_n_o));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !req_ready_o);

  // R9
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen && !done_o) |=> $stable(cnt));

  // R10
  bus_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> (dq_o == $past(dq_o)));

  // R11
  be_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_n_o) |-> (&be_n_o));
endmodule

bind ext_mem_seq emseq_chk #(.NUM_CS(NUM_CS), .DQ_W(DQ_W), .BE_W(BE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cs_n_o      (cs_n_o),
  .oe_n_o      (oe_n_o),
  .we_n_o      (we_n_o),
  .done_o      (done_o),
  .req_ready_o (req_ready_o),
  .dq_o        (dq_o),
  .dq_oe_o     (dq_oe_o),
  .be_n_o      (be_n_o),
  .frozen      (frozen),
  .cnt         (cnt)
);

// File: tb/sim_ext_mem_seq.sv
module sim_ext_mem_seq;
  import emseq_pkg::*;

  localparam int NUM_CS = 4;
  localparam int ADDR_W = 24;
  localparam int DQ_W   = 16;
  localparam int CS_W   = 2;
  localparam int BE_W   = 2;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic [NUM_CS*CFG_W-1:0] cfg_i;
  logic                    req_valid_i = 1'b0;
  logic                    req_ready_o;
  logic                    req_write_i = 1'b0;
  logic [CS_W-1:0]         req_cs_i = '0;
  logic [ADDR_W-1:0]       req_addr_i = '0;
  logic [DQ_W-1:0]         req_wdata_i = '0;
  logic [BE_W-1:0]         req_be_i = '0;
  logic                    done_o;
  logic [DQ_W-1:0]         rdata_o;
  logic [NUM_CS-1:0]       cs_n_o;
  logic                    adv_n_o, oe_n_o, we_n_o, dq_oe_o;
  logic [BE_W-1:0]         be_n_o;
  logic [ADDR_W-1:0]       addr_o;
  logic [DQ_W-1:0]         dq_o;
  logic [DQ_W-1:0]         dq_i = '0;
  logic                    wait_i = 1'b0;

  int total = 0;
  int bad = 0;
  cs_cfg_t cfgs [NUM_CS];
  logic [NUM_CS*CFG_W-1:0] cfg_pack;
  logic [DQ_W-1:0] keep = '0;

  always #2 clk_i = ~clk_i;

  ext_mem_seq #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .DQ_W(DQ_W)) u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic cs_cfg_t mk(int cs_on, int adv, int oe_on, int oe_off, int we_on,
                                 int we_off, int acc, int cyc, int turn, mux_e mx,
                                 bit wide, bit wen);
    cs_cfg_t c;
    c.cs_on = CNT_W'(cs_on);  c.adv_len = CNT_W'(adv);
    c.oe_on = CNT_W'(oe_on);  c.oe_off  = CNT_W'(oe_off);
    c.we_on = CNT_W'(we_on);  c.we_off  = CNT_W'(we_off);
    c.acc   = CNT_W'(acc);    c.cyc     = CNT_W'(cyc);
    c.turn  = CNT_W'(turn);   c.mux     = mx;
    c.wide  = wide;           c.wait_en = wen;
    return c;
  endfunction

  task automatic run_acc(input int cs, input bit wr, input logic [ADDR_W-1:0] a,
                         input logic [DQ_W-1:0] wd, input logic [BE_W-1:0] be,
                         input int wlen, input bit scramble);
    cs_cfg_t c = cfgs[cs];
    int t = 0;
    int wc = wlen;
    int ncyc = 0;
    int adv = int'(c.adv_len);
    int dstart = (c.mux == MUX_AD) ? adv : (c.mux == MUX_AAD) ? 2 * adv : 0;
    int adv_end = (c.mux == MUX_AAD) ? 2 * adv : adv;
    logic [DQ_W-1:0] exp_rd = rdata_o;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_write_i = wr; req_cs_i = CS_W'(cs);
    req_addr_i = a; req_wdata_i = wd; req_be_i = be;
    #1 chk("R7 ready before accept", 32'(req_ready_o), 32'd1);
    @(negedge clk_i);
    req_valid_i = 1'b0;
    if (scramble) cfg_i = ~cfg_pack;
    for (int guard = 0; guard < 100; guard++) begin
      bit strobe, frz, drive;
      logic [NUM_CS-1:0] e_cs;
      logic [DQ_W-1:0] pat, e_dq;
      logic [BE_W-1:0] e_be;
      string dtag;
      strobe = wr ? (t >= int'(c.we_on) && t < int'(c.we_off))
                  : (t >= int'(c.oe_on) && t < int'(c.oe_off));
      wait_i = (wc > 0) && strobe;
      pat = {8'h5A ^ 8'(t), 8'hC3 ^ 8'(t * 7)};
      dq_i = pat;
      #1;
      ncyc++;
      e_cs = '1;
      if (t >= int'(c.cs_on) && t < int'(c.cyc)) e_cs[cs] = 1'b0;
      chk("R2 chip selects", 32'(cs_n_o), 32'(e_cs));
      chk("R4 adv", 32'(adv_n_o), 32'(!(t < adv_end)));
      chk("R3 oe", 32'(oe_n_o), 32'(!(!wr && t >= int'(c.oe_on) && t < int'(c.oe_off))));
      chk("R3 we", 32'(we_n_o), 32'(!(wr && t >= int'(c.we_on) && t < int'(c.we_off))));
      drive = 1'b1;
      if (c.mux != MUX_NONE && t < adv) begin
        e_dq = (c.mux == MUX_AAD) ? DQ_W'(a >> DQ_W) : a[DQ_W-1:0]; dtag = "R5 addr phase";
      end else if (c.mux == MUX_AAD && t < 2 * adv) begin
        e_dq = a[DQ_W-1:0]; dtag = "R5 second addr phase";
      end else if (wr && t >= dstart && t < int'(c.cyc)) begin
        e_dq = c.wide ? wd : {8'h00, wd[7:0]}; dtag = "R6 write data";
      end else begin
        drive = 1'b0; e_dq = keep; dtag = "R10 bus keep";
      end
      chk(dtag, 32'(dq_oe_o), 32'(drive));
      chk(dtag, 32'(dq_o), 32'(e_dq));
      keep = e_dq;
      e_be = (e_cs[cs] == 1'b0) ? ~(c.wide ? be : (be & 2'b01)) : 2'b11;
      chk("R11 byte enables", 32'(be_n_o), 32'(e_be));
      chk("R7 done pulse", 32'(done_o), 32'(t == int'(c.cyc)));
      frz = wait_i && c.wait_en;
      if (wait_i) wc--;
      if (!wr && t == int'(c.acc) && !frz) exp_rd = c.wide ? pat : {8'h00, pat[7:0]};
      if (t == int'(c.cyc)) begin
        if (!wr) chk("R8 read data", 32'(rdata_o), 32'(exp_rd));
        chk("R9 R12 access length", 32'(ncyc),
            32'(int'(c.cyc) + 1 + (c.wait_en ? wlen : 0)));
        break;
      end
      if (!frz) t++;
      @(negedge clk_i);
    end
    wait_i = 1'b0;
    cfg_i = cfg_pack;
    for (int k = 0; k < int'(c.turn); k++) begin
      @(negedge clk_i); #1;
      chk("R7 ready low in turnaround", 32'(req_ready_o), 32'd0);
      chk("R2 no chip select in turnaround", 32'(cs_n_o), 32'hF);
      chk("R10 bus keep in turnaround", 32'(dq_o), 32'(keep));
    end
    @(negedge clk_i); #1;
    chk("R7 ready after turnaround", 32'(req_ready_o), 32'd1);
    if (!wr) chk("R8 read data held", 32'(rdata_o), 32'(exp_rd));
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog R7 act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cfgs[0] = mk(1, 2, 2, 6, 2, 5, 5, 7, 2, MUX_NONE, 1'b1, 1'b1);
    cfgs[1] = mk(0, 2, 3, 7, 3, 6, 6, 8, 1, MUX_AD,   1'b1, 1'b0);
    cfgs[2] = mk(0, 2, 5, 9, 5, 8, 8, 10, 3, MUX_AAD, 1'b0, 1'b1);
    cfgs[3] = mk(0, 1, 1, 3, 1, 3, 2, 3, 0, MUX_NONE, 1'b0, 1'b0);
    cfg_pack = {cfgs[3], cfgs[2], cfgs[1], cfgs[0]};
    cfg_i = cfg_pack;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 reset cs", 32'(cs_n_o), 32'hF);
    chk("R1 reset strobes", 32'({adv_n_o, oe_n_o, we_n_o}), 32'h7);
    chk("R1 reset done/oe", 32'({done_o, dq_oe_o}), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk("R1 ready after reset", 32'(req_ready_o), 32'd1);
    chk("R1 idle cs", 32'(cs_n_o), 32'hF);
    for (int cs = 0; cs < NUM_CS; cs++)
      for (int wr = 0; wr < 2; wr++)
        for (int w = 0; w < 2; w++)
          for (int sc = 0; sc < 2; sc++)
            run_acc(cs, wr[0], ADDR_W'(24'h3A0000 + cs * 24'h1357 + w * 24'h0200 + sc),
                    DQ_W'(16'hB100 + cs * 16'h1111 + w * 16'h22 + sc * 16'h4),
                    sc[0] ? 2'b10 : 2'b11, w * 2, sc[0]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule